// File: doc/BRIEF.md
# Parallel-Translate Data Cache Lookup

This block is the load-lookup stage of a first-level data cache that is set-associative and holds its tags as physical addresses. A request carries a virtual address. The set is chosen from address bits that lie wholly inside the 4 KiB page offset, so those bits are identical before and after translation. The tag array and the data array can therefore be read in the same cycle that a small fully associative translation buffer turns the virtual page number into a physical frame number. In the following cycle the frame is compared against the stored physical tag of every way. That comparison yields the hit, and it also picks the 64-bit word returned to the load.

The default geometry is 32 KiB in 8 ways of 64-byte lines, which gives 64 sets indexed by address bits 11:6. The translation buffer has 16 entries. Software or a page walker outside this block loads translations through a fill port. Lines arrive from the next level through a line-fill port that carries a physical address. Because every tag is physical, an invalidation that presents a physical address removes the line no matter which virtual alias was used to bring it in.

Top module: `vipt_lookup`

## Requirements
- R1: After a synchronous active-low reset, every translation entry and every cache line is invalid. A request then reports a translation miss, and once a translation is loaded it reports a cache miss until a line is filled.
- R2: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high, and low otherwise.
- R3: When no valid translation entry matches bits 31:12 of the request, the response has `rsp_tlb_miss`=1, `rsp_hit`=0 and `rsp_data`=0.
- R4: When the translated frame equals the stored tag (physical bits 35:12) of a valid way in set `vaddr[11:6]`, the response has `rsp_hit`=1 and `rsp_data` holds word `vaddr[5:3]` of that line. Word k occupies line bits 64k+63 down to 64k. Otherwise `rsp_hit`=0 and `rsp_data`=0.
- R5: Two virtual pages that map to the same frame both hit the same line, and each returns the same data for the same offset.
- R6: A snoop-invalidate with physical address P clears the valid way in set P[11:6] whose tag equals P[35:12]. This happens whichever alias filled the line. Other ways of that set keep their lines.
- R7: A line fill whose tag is not already valid in its set is written to the way named by that set's round-robin pointer. The pointer resets to 0 and advances by one on each such fill. The ninth distinct tag filled into a set evicts the first, and other sets are not affected.
- R8: A line fill whose tag is already valid in its set overwrites that way's data in place and does not advance the pointer.
- R9: A translation fill whose page number is already valid updates that entry in place. Otherwise it is written at a round-robin slot that resets to 0 and advances on each new allocation, so the seventeenth distinct page evicts the first.
- R10: At most one way of a set matches a given frame, and at most one translation entry matches a given page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 32 | Virtual address of the load |
| tlb_fill_valid | input | 1 | Write a translation |
| tlb_fill_vpn | input | 20 | Virtual page number to install |
| tlb_fill_pfn | input | 24 | Physical frame number for that page |
| line_fill_valid | input | 1 | Write a cache line |
| line_fill_paddr | input | 36 | Physical address of the line (bits 5:0 ignored) |
| line_fill_data | input | 512 | Line contents, word k at bits 64k+63:64k |
| snoop_valid | input | 1 | Invalidate by physical address |
| snoop_paddr | input | 36 | Physical address to invalidate (bits 5:0 ignored) |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Line found under the translated frame |
| rsp_tlb_miss | output | 1 | No translation for the page |
| rsp_data | output | 64 | Selected word on a hit, zero otherwise |

## Verification
The cases that are hardest to reach from the ports are a snoop that must remove a line filled through a different virtual alias, and eviction in a set that is full while the translation buffer itself is cycling. The random stimulus draws pages, frames and sets from small pools: 24 pages, 12 frames and 4 sets. With those pools, aliases, full sets, refills of a resident tag and translation evictions all happen often. Directed sequences fill one set with nine tags, refill a resident tag, and then install a seventeenth page, each with a known expected outcome.

// File: rtl/vipt_pkg.sv
`timescale 1ns/1ps
// Shared geometry and types for the parallel-translate cache lookup.
// Assumes the set index plus line offset fit inside the page offset.
package vipt_pkg;
    localparam int VA_W       = 32;
    localparam int PA_W       = 36;
    localparam int PAGE_BITS  = 12;
    localparam int CAP_BYTES  = 32768;
    localparam int LINE_BYTES = 64;
    localparam int WAYS       = 8;
    localparam int WORD_W     = 64;
    localparam int TLB_N      = 16;

    localparam int SETS     = CAP_BYTES / (LINE_BYTES * WAYS);
    localparam int OFF_BITS = $clog2(LINE_BYTES);
    localparam int IDX_BITS = $clog2(SETS);
    localparam int VPN_W    = VA_W - PAGE_BITS;
    localparam int PFN_W    = PA_W - PAGE_BITS;
    localparam int TAG_W    = PA_W - OFF_BITS - IDX_BITS;
    localparam int LINE_W   = LINE_BYTES * 8;
    localparam int WORDS    = LINE_W / WORD_W;
    localparam int WSEL_W   = $clog2(WORDS);
    localparam int BYTE_SEL = $clog2(WORD_W / 8);
    localparam int WAY_W    = $clog2(WAYS);
    localparam int TLB_W    = $clog2(TLB_N);

    typedef logic [VPN_W-1:0]    vpn_t;
    typedef logic [PFN_W-1:0]    pfn_t;
    typedef logic [TAG_W-1:0]    tag_t;
    typedef logic [IDX_BITS-1:0] idx_t;
    typedef logic [WAY_W-1:0]    way_t;
    typedef logic [WSEL_W-1:0]   wsel_t;
    typedef logic [LINE_W-1:0]   line_t;
    typedef logic [WORD_W-1:0]   word_t;
endpackage

// File: rtl/vipt_tlb.sv
`timescale 1ns/1ps
// Fully associative translation buffer: combinational lookup of a page
// number, and a fill port that updates a resident page in place or
// allocates a round-robin slot. Assumes at most one fill per cycle.
module vipt_tlb
    import vipt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  vpn_t lk_vpn,
    output logic lk_hit,
    output pfn_t lk_pfn,
    input  logic fill_en,
    input  vpn_t fill_vpn,
    input  pfn_t fill_pfn
);
    vpn_t               vpn_q [TLB_N];
    pfn_t               pfn_q [TLB_N];
    logic [TLB_N-1:0]   val_q;
    logic [TLB_W-1:0]   rr_q;
    logic [TLB_N-1:0]   lk_match;
    logic [TLB_N-1:0]   fill_match;

    // Compare the lookup and fill page numbers against every entry.
    for (genvar i = 0; i < TLB_N; i++) begin : g_cmp
        assign lk_match[i]   = val_q[i] && (vpn_q[i] == lk_vpn);
        assign fill_match[i] = val_q[i] && (vpn_q[i] == fill_vpn);
    end

    // Merge the frame of the single matching entry.
    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < TLB_N; i++)
            if (lk_match[i]) lk_pfn = lk_pfn | pfn_q[i];
        lk_hit = |lk_match;
    end

    // Valid bits and allocation pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
            rr_q  <= '0;
        end else if (fill_en && !(|fill_match)) begin
            val_q[rr_q] <= 1'b1;
            rr_q        <= rr_q + 1'b1;
        end
    end

    // Entry contents: in place on a resident page, else at the pointer.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            if (|fill_match) begin
                for (int i = 0; i < TLB_N; i++)
                    if (fill_match[i]) pfn_q[i] <= fill_pfn;
            end else begin
                vpn_q[rr_q] <= fill_vpn;
                pfn_q[rr_q] <= fill_pfn;
            end
        end
    end

    assert_tlb_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
endmodule

// File: rtl/vipt_tag_array.sv
`timescale 1ns/1ps
// Physical tag and valid store with per-set round-robin way choice.
// Reads a whole set into registers; fills and snoop-invalidates take
// effect at the clock edge, after the same-cycle read.
module vipt_tag_array
    import vipt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  idx_t             rd_idx,
    output tag_t             rd_tags [WAYS],
    output logic [WAYS-1:0]  rd_valid,
    input  logic             fill_en,
    input  idx_t             fill_idx,
    input  tag_t             fill_tag,
    output way_t             fill_way,
    input  logic             inv_en,
    input  idx_t             inv_idx,
    input  tag_t             inv_tag
);
    tag_t            tag_q [SETS][WAYS];
    logic [WAYS-1:0] val_q [SETS];
    way_t            rr_q  [SETS];
    logic [WAYS-1:0] fill_match;
    logic [WAYS-1:0] inv_match;
    way_t            fill_hit_way;

    // Tag comparison for the fill and invalidate sets.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign fill_match[w] = val_q[fill_idx][w] && (tag_q[fill_idx][w] == fill_tag);
        assign inv_match[w]  = val_q[inv_idx][w]  && (tag_q[inv_idx][w]  == inv_tag);
    end

    // Pick the resident way on a refill, else the round-robin way.
    always_comb begin
        fill_hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (fill_match[w]) fill_hit_way = way_t'(w);
        fill_way = (|fill_match) ? fill_hit_way : rr_q[fill_idx];
    end

    // Valid bits, pointers and the registered set read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                val_q[s] <= '0;
                rr_q[s]  <= '0;
            end
            rd_valid <= '0;
        end else begin
            if (inv_en)
                val_q[inv_idx] <= val_q[inv_idx] & ~inv_match;
            if (fill_en) begin
                val_q[fill_idx][fill_way] <= 1'b1;
                if (!(|fill_match)) rr_q[fill_idx] <= rr_q[fill_idx] + 1'b1;
            end
            if (rd_en) rd_valid <= val_q[rd_idx];
        end
    end

    // Tag storage and tag read of the requested set.
    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_idx][fill_way] <= fill_tag;
        if (rd_en)
            for (int w = 0; w < WAYS; w++) rd_tags[w] <= tag_q[rd_idx][w];
    end

    // Checker state: remember the last snoop and fill for the properties.
    logic inv_chk_q, fill_chk_q, inv_left, fill_seen;
    idx_t inv_idx_q, fill_idx_q;
    tag_t inv_tag_q, fill_tag_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_chk_q  <= 1'b0;
            fill_chk_q <= 1'b0;
        end else begin
            inv_chk_q  <= inv_en && !fill_en;
            fill_chk_q <= fill_en && !inv_en;
        end
        inv_idx_q  <= inv_idx;
        inv_tag_q  <= inv_tag;
        fill_idx_q <= fill_idx;
        fill_tag_q <= fill_tag;
    end

    // Search the remembered sets for the remembered tags.
    always_comb begin
        inv_left  = 1'b0;
        fill_seen = 1'b0;
        for (int w = 0; w < WAYS; w++) begin
            if (val_q[inv_idx_q][w] && tag_q[inv_idx_q][w] == inv_tag_q) inv_left = 1'b1;
            if (val_q[fill_idx_q][w] && tag_q[fill_idx_q][w] == fill_tag_q) fill_seen = 1'b1;
        end
    end

    assert_snoop_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        inv_chk_q |-> !inv_left);
    assert_fill_present_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_chk_q |-> fill_seen);
    assert_fill_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_match));
endmodule

// File: rtl/vipt_data_array.sv
`timescale 1ns/1ps
// Line data store. Writes a whole line into a given set and way; reads
// the selected word of every way of a set into registers.
module vipt_data_array
    import vipt_pkg::*;
(
    input  logic  clk,
    input  logic  wr_en,
    input  idx_t  wr_idx,
    input  way_t  wr_way,
    input  line_t wr_line,
    input  logic  rd_en,
    input  idx_t  rd_idx,
    input  wsel_t rd_wsel,
    output word_t rd_words [WAYS]
);
    line_t mem [SETS][WAYS];

    // Line write and per-way word read; read returns pre-write contents.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx][wr_way] <= wr_line;
        if (rd_en)
            for (int w = 0; w < WAYS; w++)
                rd_words[w] <= mem[rd_idx][w][rd_wsel*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/vipt_lookup.sv
`timescale 1ns/1ps
// Load lookup for a physically tagged cache indexed by untranslated
// page-offset bits. Cycle 0: set read and translation in parallel.
// Cycle 1: physical tag compare, hit and word select on the outputs.
// Assumes index and line-offset bits lie inside the page offset.
module vipt_lookup
    import vipt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              tlb_fill_valid,
    input  logic [VPN_W-1:0]  tlb_fill_vpn,
    input  logic [PFN_W-1:0]  tlb_fill_pfn,
    input  logic              line_fill_valid,
    input  logic [PA_W-1:0]   line_fill_paddr,
    input  logic [LINE_W-1:0] line_fill_data,
    input  logic              snoop_valid,
    input  logic [PA_W-1:0]   snoop_paddr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_tlb_miss,
    output logic [WORD_W-1:0] rsp_data
);
    localparam int IDX_LO = OFF_BITS;
    localparam int IDX_HI = OFF_BITS + IDX_BITS - 1;

    idx_t            req_idx, fill_idx, snp_idx;
    wsel_t           req_wsel;
    vpn_t            req_vpn;
    tag_t            fill_tag, snp_tag;
    logic            tlb_hit;
    pfn_t            tlb_pfn;
    way_t            fill_way;
    tag_t            rd_tags  [WAYS];
    logic [WAYS-1:0] rd_valid;
    word_t           rd_words [WAYS];
    logic            rsp_valid_q, tlb_hit_q;
    pfn_t            pfn_q;
    logic [WAYS-1:0] way_hit;
    word_t           sel_word;
    logic            unused_bits;

    assign req_idx  = req_vaddr[IDX_HI:IDX_LO];
    assign req_wsel = req_vaddr[OFF_BITS-1:BYTE_SEL];
    assign req_vpn  = req_vaddr[VA_W-1:PAGE_BITS];
    assign fill_idx = line_fill_paddr[IDX_HI:IDX_LO];
    assign fill_tag = line_fill_paddr[PA_W-1:IDX_HI+1];
    assign snp_idx  = snoop_paddr[IDX_HI:IDX_LO];
    assign snp_tag  = snoop_paddr[PA_W-1:IDX_HI+1];
    assign unused_bits = ^{req_vaddr[BYTE_SEL-1:0], line_fill_paddr[OFF_BITS-1:0],
                           snoop_paddr[OFF_BITS-1:0]};

    vipt_tlb u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_vpn   (req_vpn),
        .lk_hit   (tlb_hit),
        .lk_pfn   (tlb_pfn),
        .fill_en  (tlb_fill_valid),
        .fill_vpn (tlb_fill_vpn),
        .fill_pfn (tlb_fill_pfn)
    );

    vipt_tag_array u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (req_valid),
        .rd_idx   (req_idx),
        .rd_tags  (rd_tags),
        .rd_valid (rd_valid),
        .fill_en  (line_fill_valid),
        .fill_idx (fill_idx),
        .fill_tag (fill_tag),
        .fill_way (fill_way),
        .inv_en   (snoop_valid),
        .inv_idx  (snp_idx),
        .inv_tag  (snp_tag)
    );

    vipt_data_array u_data (
        .clk      (clk),
        .wr_en    (line_fill_valid),
        .wr_idx   (fill_idx),
        .wr_way   (fill_way),
        .wr_line  (line_fill_data),
        .rd_en    (req_valid),
        .rd_idx   (req_idx),
        .rd_wsel  (req_wsel),
        .rd_words (rd_words)
    );

    // Capture the translation result alongside the set read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            tlb_hit_q   <= 1'b0;
            pfn_q       <= '0;
        end else begin
            rsp_valid_q <= req_valid;
            if (req_valid) begin
                tlb_hit_q <= tlb_hit;
                pfn_q     <= tlb_pfn;
            end
        end
    end

    // Physical tag compare in every way.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_hit[w] = rd_valid[w] && (rd_tags[w] == pfn_q);
    end

    // Merge the word of the single hitting way and drive the response.
    always_comb begin
        sel_word = '0;
        for (int w = 0; w < WAYS; w++)
            if (way_hit[w]) sel_word = sel_word | rd_words[w];
        rsp_valid    = rsp_valid_q;
        rsp_tlb_miss = rsp_valid_q && !tlb_hit_q;
        rsp_hit      = rsp_valid_q && tlb_hit_q && (|way_hit);
        rsp_data     = rsp_hit ? sel_word : '0;
    end

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_rsp_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_miss_no_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_tlb_miss |-> (!rsp_hit && rsp_data == '0));
    assert_way_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot0(way_hit));
endmodule

// File: tb/test_vipt_lookup.sv
`timescale 1ns/1ps
module test_vipt_lookup;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_vaddr = '0;
    logic          tlb_fill_valid = 1'b0;
    logic [19:0]   tlb_fill_vpn = '0;
    logic [23:0]   tlb_fill_pfn = '0;
    logic          line_fill_valid = 1'b0;
    logic [35:0]   line_fill_paddr = '0;
    logic [511:0]  line_fill_data = '0;
    logic          snoop_valid = 1'b0;
    logic [35:0]   snoop_paddr = '0;
    logic          rsp_valid, rsp_hit, rsp_tlb_miss;
    logic [63:0]   rsp_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    vipt_lookup i_vipt_lookup (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .tlb_fill_valid(tlb_fill_valid), .tlb_fill_vpn(tlb_fill_vpn), .tlb_fill_pfn(tlb_fill_pfn),
        .line_fill_valid(line_fill_valid), .line_fill_paddr(line_fill_paddr),
        .line_fill_data(line_fill_data), .snoop_valid(snoop_valid), .snoop_paddr(snoop_paddr),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_tlb_miss(rsp_tlb_miss), .rsp_data(rsp_data)
    );

    // Reference state
    logic [23:0]  m_tag  [64][8];
    bit           m_val  [64][8];
    logic [511:0] m_data [64][8];
    int           m_rr   [64];
    logic [19:0]  t_vpn  [16];
    logic [23:0]  t_pfn  [16];
    bit           t_val  [16];
    int           t_rr;

    task automatic model_reset();
        for (int s = 0; s < 64; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < 8; w++) m_val[s][w] = 0;
        end
        for (int i = 0; i < 16; i++) t_val[i] = 0;
        t_rr = 0;
    endtask

    task automatic check(string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic model_lookup(logic [31:0] va, output bit hit, output bit tmiss,
                                output logic [63:0] data);
        bit found = 0;
        logic [23:0] pfn = '0;
        int s = int'(va[11:6]);
        hit = 0; data = '0;
        for (int i = 0; i < 16; i++)
            if (t_val[i] && t_vpn[i] == va[31:12]) begin found = 1; pfn = t_pfn[i]; end
        tmiss = !found;
        if (found)
            for (int w = 0; w < 8; w++)
                if (m_val[s][w] && m_tag[s][w] == pfn) begin
                    hit = 1;
                    data = m_data[s][w][int'(va[5:3])*64 +: 64];
                end
    endtask

    task automatic finish_cycle();
        @(negedge clk);
        req_valid = 0; tlb_fill_valid = 0; line_fill_valid = 0; snoop_valid = 0;
    endtask

    task automatic do_req(string rq, logic [31:0] va);
        bit eh, et;
        logic [63:0] ed;
        model_lookup(va, eh, et, ed);
        req_valid = 1; req_vaddr = va;
        finish_cycle();
        check("R2", "rsp_valid", 64'(rsp_valid), 64'd1);
        check(et ? "R3" : rq, "rsp_tlb_miss", 64'(rsp_tlb_miss), 64'(et));
        check(rq, "rsp_hit", 64'(rsp_hit), 64'(eh));
        check(rq, "rsp_data", rsp_data, ed);
    endtask

    task automatic do_tlb_fill(logic [19:0] vpn, logic [23:0] pfn);
        bit done = 0;
        for (int i = 0; i < 16; i++)
            if (t_val[i] && t_vpn[i] == vpn) begin t_pfn[i] = pfn; done = 1; end
        if (!done) begin
            t_vpn[t_rr] = vpn; t_pfn[t_rr] = pfn; t_val[t_rr] = 1; t_rr = (t_rr + 1) % 16;
        end
        tlb_fill_valid = 1; tlb_fill_vpn = vpn; tlb_fill_pfn = pfn;
        finish_cycle();
        check("R2", "idle rsp_valid", 64'(rsp_valid), 64'd0);
    endtask

    task automatic do_line_fill(logic [35:0] pa, logic [511:0] d);
        int s = int'(pa[11:6]);
        int way = -1;
        for (int w = 0; w < 8; w++)
            if (m_val[s][w] && m_tag[s][w] == pa[35:12]) way = w;
        if (way < 0) begin way = m_rr[s]; m_rr[s] = (m_rr[s] + 1) % 8; end
        m_tag[s][way] = pa[35:12]; m_val[s][way] = 1; m_data[s][way] = d;
        line_fill_valid = 1; line_fill_paddr = pa; line_fill_data = d;
        finish_cycle();
    endtask

    task automatic do_snoop(logic [35:0] pa);
        int s = int'(pa[11:6]);
        for (int w = 0; w < 8; w++)
            if (m_val[s][w] && m_tag[s][w] == pa[35:12]) m_val[s][w] = 0;
        snoop_valid = 1; snoop_paddr = pa;
        finish_cycle();
    endtask

    function automatic logic [511:0] rnd_line();
        logic [511:0] d;
        for (int k = 0; k < 16; k++) d[k*32 +: 32] = $urandom();
        return d;
    endfunction

    function automatic logic [35:0] pa_of(logic [23:0] pfn, int set);
        return {pfn, 6'(set), 6'd0};
    endfunction

    function automatic logic [31:0] va_of(logic [19:0] vpn, int set, int word);
        return {vpn, 6'(set), 3'(word), 3'd5};
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        finish_cycle();
        check("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
        do_req("R1", va_of(20'h00010, 5, 3));
        do_tlb_fill(20'h00010, 24'h000ABC);
        do_req("R1", va_of(20'h00010, 5, 3));

        // Hit, alias and translation miss
        do_line_fill(pa_of(24'h000ABC, 5), rnd_line());
        do_req("R4", va_of(20'h00010, 5, 3));
        do_req("R4", va_of(20'h00010, 5, 0));
        do_tlb_fill(20'h00020, 24'h000ABC);
        do_req("R5", va_of(20'h00020, 5, 3));
        do_req("R5", va_of(20'h00020, 5, 7));
        do_req("R3", va_of(20'h77777, 5, 3));

        // Snoop through a physical address filled via another alias
        do_tlb_fill(20'h00030, 24'h000BBB);
        do_line_fill(pa_of(24'h000BBB, 5), rnd_line());
        do_snoop(pa_of(24'h000ABC, 5));
        do_req("R6", va_of(20'h00020, 5, 2));
        do_req("R6", va_of(20'h00010, 5, 2));
        do_req("R6", va_of(20'h00030, 5, 2));

        // Nine distinct tags into set 9, then refill in place
        for (int i = 0; i < 9; i++) begin
            do_tlb_fill(20'h00100 + 20'(i), 24'h000200 + 24'(i));
            do_line_fill(pa_of(24'h000200 + 24'(i), 9), rnd_line());
        end
        do_req("R7", va_of(20'h00100, 9, 1));
        do_req("R7", va_of(20'h00108, 9, 1));
        do_req("R7", va_of(20'h00030, 5, 1));
        do_line_fill(pa_of(24'h000203, 9), rnd_line());
        do_req("R8", va_of(20'h00103, 9, 4));
        do_line_fill(pa_of(24'h000209, 9), rnd_line());
        do_req("R8", va_of(20'h00101, 9, 4));
        do_req("R8", va_of(20'h00102, 9, 4));
        do_req("R8", va_of(20'h00103, 9, 6));

        // Translation buffer: fill to capacity, update in place, evict
        for (int i = 0; i < 4; i++) do_tlb_fill(20'h00300 + 20'(i), 24'h000300 + 24'(i));
        do_tlb_fill(20'h00010, 24'h000BBB);
        do_req("R9", va_of(20'h00010, 5, 5));
        do_tlb_fill(20'h00400, 24'h000BBB);
        do_req("R9", va_of(20'h00010, 5, 5));
        do_req("R9", va_of(20'h00400, 5, 5));
        do_req("R9", va_of(20'h00020, 5, 5));

        // Constrained random mix
        for (int n = 0; n < 4000; n++) begin
            int op = int'($urandom_range(0, 99));
            logic [19:0] vpn = 20'h00500 + 20'($urandom_range(0, 23));
            logic [23:0] pfn = 24'h000600 + 24'($urandom_range(0, 11));
            int set = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 63))
                                                  : int'($urandom_range(0, 3));
            if (op < 40)      do_req("R4", va_of(vpn, set, int'($urandom_range(0, 7))));
            else if (op < 55) do_tlb_fill(vpn, pfn);
            else if (op < 80) do_line_fill(pa_of(pfn, set), rnd_line());
            else if (op < 90) do_snoop(pa_of(pfn, set));
            else begin
                finish_cycle();
                check("R2", "idle rsp_valid", 64'(rsp_valid), 64'd0);
            end
        end

        // Reset clears everything again
        rst_n = 0;
        finish_cycle();
        rst_n = 1;
        model_reset();
        do_req("R1", va_of(20'h00500, 1, 1));
        summary();
    end
endmodule